// File: doc/BRIEF.md
# Hysteresis On/Off Link Backpressure Controller

This block tracks how many slots of one receive buffer are free and turns that number into a single on/off permission bit for the sender. Each arriving flit takes a slot and each accepted dequeue gives one back. The permission bit does not change on every flit. It drops only when the free count falls under a low threshold, and it rises again only when the free count climbs over a higher threshold. Between the two thresholds the bit keeps its last value, so the link needs very few signaling events.

The permission bit is registered. It then passes through a parameterized chain of registers that models the wire delay back to the sender. On the sending side, a gate lets a flit out only while the delayed bit reads "on". A sent flit lands in the buffer in the same cycle it is launched. The low threshold has to cover every flit that can still be launched after the buffer crosses it. The high threshold sets how much data is still queued when sending resumes. The flit data itself is not stored here; the block handles occupancy only.

Top module: `onoff_bp_ctrl`

## Requirements
- R1: After synchronous reset, `free_cnt` equals DEPTH, `link_on` is 1, `gate_on` is 1 and `link_evt` is 0.
- R2: At each clock edge, `free_cnt` drops by one for a sent flit (`up_send`=1) and rises by one for an accepted dequeue (`deq_ok`=1). When both happen in the same cycle, it stays the same.
- R3: When `free_cnt` equals DEPTH, a dequeue request is ignored: `deq_ok` is 0 and `free_cnt` does not change.
- R4: When `link_on` is 1 and `free_cnt` is below FOFF, `link_on` is 0 after the next edge.
- R5: When `link_on` is 0 and `free_cnt` is above FON, `link_on` is 1 after the next edge.
- R6: When `free_cnt` lies between FOFF and FON, both included, `link_on` keeps its value.
- R7: `link_evt` is 1 for exactly the cycles in which `link_on` differs from its value in the previous cycle, and is 0 in all other cycles.
- R8: `gate_on` equals the value `link_on` held DELAY cycles earlier. Before the reset has been released for that many cycles, it reads 1.
- R9: `up_send` is `up_want` AND `gate_on`, with no register in that path.
- R10: With FOFF >= DELAY+2, a flit is never sent while `free_cnt` is 0 unless a dequeue is accepted in the same cycle. As a result, the count never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_want | input | 1 | Sender has a flit ready |
| deq_req | input | 1 | Receiver asks to remove one flit from the buffer |
| up_send | output | 1 | Flit launched this cycle, entering the buffer |
| deq_ok | output | 1 | Dequeue accepted this cycle |
| free_cnt | output | $clog2(DEPTH+1) | Registered count of free slots |
| link_on | output | 1 | Registered receive-side permission state |
| link_evt | output | 1 | One-cycle pulse on every permission change |
| gate_on | output | 1 | Permission as seen by the sender after the delay |

## Verification
Two updates can land on the count in the same cycle: a launched flit takes a slot while an accepted dequeue frees one. The bench provokes this with long stretches where both inputs are held high. It also runs random phases in which the launch stops at the gate while dequeues continue. In every cycle, the count is judged against a bench model that applies both deltas together. A second overlap is a threshold crossing that happens in the same cycle as an opposing count change. Here the model checks that the state follows the registered count, not the inputs of that cycle.

// File: rtl/obp_pkg.sv
package obp_pkg;
  typedef enum logic {
    LINK_OFF = 1'b0,
    LINK_ON  = 1'b1
  } link_state_e;
endpackage

// File: rtl/obp_occ.sv
module obp_occ #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arrive,
  input  logic          deq_req,
  output logic          deq_ok,
  output logic [CW-1:0] free_q
);
  localparam logic [CW-1:0] ALL_FREE = CW'(DEPTH);

  // A dequeue is only honoured when at least one slot is occupied.
  assign deq_ok = deq_req && (free_q != ALL_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= ALL_FREE;
    end else begin
      unique case ({arrive, deq_ok})
        2'b10:   if (free_q != '0) free_q <= free_q - 1'b1;
        2'b01:   free_q <= free_q + 1'b1;
        default: free_q <= free_q;
      endcase
    end
  end
endmodule

// File: rtl/obp_hyst.sv
module obp_hyst
  import obp_pkg::*;
#(
  parameter int CW   = 5,
  parameter int FOFF = 6,
  parameter int FON  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] free_q,
  output link_state_e   state_q,
  output logic          evt_q
);
  localparam logic [CW-1:0] LO_MARK = CW'(FOFF);
  localparam logic [CW-1:0] HI_MARK = CW'(FON);

  link_state_e nxt;

  always_comb begin
    nxt = state_q;
    if (state_q == LINK_ON && free_q < LO_MARK)       nxt = LINK_OFF;
    else if (state_q == LINK_OFF && free_q > HI_MARK) nxt = LINK_ON;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINK_ON;
      evt_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      evt_q   <= (nxt != state_q);
    end
  end
endmodule

// File: rtl/obp_sigdelay.sv
module obp_sigdelay #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (DELAY == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= 1'b1;
        else     r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      logic [DELAY-1:0] sr_q;
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= {sr_q[DELAY-2:0], d};
      end
      assign q = sr_q[DELAY-1];
    end
  endgenerate
endmodule

// File: rtl/onoff_bp_ctrl.sv
module onoff_bp_ctrl
  import obp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FOFF  = 6,
  parameter int FON   = 10,
  parameter int DELAY = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_want,
  input  logic          deq_req,
  output logic          up_send,
  output logic          deq_ok,
  output logic [CW-1:0] free_cnt,
  output logic          link_on,
  output logic          link_evt,
  output logic          gate_on
);
  link_state_e st;

  assign up_send = up_want & gate_on;

  obp_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk), .rst(rst), .arrive(up_send), .deq_req(deq_req),
    .deq_ok(deq_ok), .free_q(free_cnt)
  );

  obp_hyst #(.CW(CW), .FOFF(FOFF), .FON(FON)) u_hyst (
    .clk(clk), .rst(rst), .free_q(free_cnt), .state_q(st), .evt_q(link_evt)
  );

  assign link_on = (st == LINK_ON);

  obp_sigdelay #(.DELAY(DELAY)) u_dly (
    .clk(clk), .rst(rst), .d(link_on), .q(gate_on)
  );
endmodule

// File: rtl/obp_checker.sv
module obp_checker #(
  parameter int DEPTH = 16,
  parameter int FOFF  = 6,
  parameter int FON   = 10,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          up_want,
  input logic          up_send,
  input logic          deq_ok,
  input logic [CW-1:0] free_cnt,
  input logic          link_on,
  input logic          link_evt,
  input logic          gate_on
);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (free_cnt == '0) |-> !(up_send && !deq_ok));

  assert_empty_deq_R3: assert property (@(posedge clk) disable iff (rst)
    (free_cnt == CW'(DEPTH)) |-> !deq_ok);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CW'(DEPTH));

  assert_go_off_R4: assert property (@(posedge clk) disable iff (rst)
    (link_on && free_cnt < CW'(FOFF)) |=> !link_on);

  assert_go_on_R5: assert property (@(posedge clk) disable iff (rst)
    (!link_on && free_cnt > CW'(FON)) |=> link_on);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (free_cnt >= CW'(FOFF) && free_cnt <= CW'(FON)) |=> $stable(link_on));

  assert_evt_R7: assert property (@(posedge clk) disable iff (rst)
    link_evt |-> (link_on != $past(link_on)));

  assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
    up_send == (up_want && gate_on));
endmodule

bind onoff_bp_ctrl obp_checker #(
  .DEPTH(DEPTH), .FOFF(FOFF), .FON(FON), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .up_want(up_want), .up_send(up_send),
  .deq_ok(deq_ok), .free_cnt(free_cnt), .link_on(link_on),
  .link_evt(link_evt), .gate_on(gate_on)
);

// File: tb/onoff_bp_ctrl_tb.sv
`timescale 1ns/1ps
module onoff_bp_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int FOFF  = 6;
  localparam int FON   = 10;
  localparam int DELAY = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_want = 1'b0;
  logic deq_req = 1'b0;
  logic up_send, deq_ok, link_on, link_evt, gate_on;
  logic [CW-1:0] free_cnt;

  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  int m_free;
  bit m_on, m_evt;
  bit [DELAY-1:0] m_pipe;
  bit m_send, m_deq;

  always #2.5 clk = ~clk;

  onoff_bp_ctrl #(.DEPTH(DEPTH), .FOFF(FOFF), .FON(FON), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst(rst), .up_want(up_want), .deq_req(deq_req),
    .up_send(up_send), .deq_ok(deq_ok), .free_cnt(free_cnt),
    .link_on(link_on), .link_evt(link_evt), .gate_on(gate_on)
  );

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit next_state(bit on, int fr);
    if (on && fr < FOFF) return 1'b0;
    if (!on && fr > FON) return 1'b1;
    return on;
  endfunction

  task automatic model_reset();
    m_free = DEPTH; m_on = 1'b1; m_evt = 1'b0; m_pipe = '1;
  endtask

  task automatic step(bit want, bit deq);
    int nf;
    bit ns;
    @(negedge clk);
    chk("R2 R10 free_cnt", int'(free_cnt), m_free);
    chk("R4 R5 R6 link_on", int'(link_on), int'(m_on));
    chk("R7 link_evt", int'(link_evt), int'(m_evt));
    chk("R8 gate_on", int'(gate_on), int'(m_pipe[DELAY-1]));
    up_want = want;
    deq_req = deq;
    #1;
    m_send = want & m_pipe[DELAY-1];
    m_deq  = deq & (m_free < DEPTH);
    chk("R9 up_send", int'(up_send), int'(m_send));
    chk("R3 deq_ok", int'(deq_ok), int'(m_deq));
    @(posedge clk);
    nf = m_free - int'(m_send) + int'(m_deq);
    ns = next_state(m_on, m_free);
    m_evt  = (ns != m_on);
    m_pipe = {m_pipe[DELAY-2:0], m_on};
    m_on   = ns;
    m_free = nf;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk("R1 free_cnt", int'(free_cnt), DEPTH);
    chk("R1 link_on", int'(link_on), 1);
    chk("R1 gate_on", int'(gate_on), 1);
    chk("R1 link_evt", int'(link_evt), 0);
    // R3: dequeue on an empty buffer
    repeat (3) step(1'b0, 1'b1);
    // fill until the gate closes: R4 and R10 worst case
    repeat (30) step(1'b1, 1'b0);
    // simultaneous send and dequeue while full-ish: R2
    repeat (10) step(1'b1, 1'b1);
    // drain past FON: R5, then empty: R3
    repeat (30) step(1'b0, 1'b1);
    // constant both high from empty
    repeat (20) step(1'b1, 1'b1);
    // random phases
    for (int ph = 0; ph < 60; ph++) begin
      int pw = $urandom_range(10, 95);
      int pd = $urandom_range(5, 90);
      for (int k = 0; k < 40; k++)
        step(($urandom_range(0, 99) < pw), ($urandom_range(0, 99) < pd));
    end
    // reset mid-run returns to R1 state
    @(negedge clk);
    rst = 1'b1;
    up_want = 1'b0; deq_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 free_cnt after rerun", int'(free_cnt), DEPTH);
    chk("R1 link_on after rerun", int'(link_on), 1);
    repeat (5) step(1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule